// File: doc/BRIEF.md
# Staged power-up reset sequencer

This block holds a processor subsystem in reset after power is applied and releases it through a fixed chain of qualified stages. It runs on an always-on reference clock. It watches two digitized supply comparator flags: a low threshold for power-on and a higher threshold for brown-out. Each stage waits for its own programmable delay before the next one begins. The chain runs in this order: power-on settle, brown-out settle, power-up timer, oscillator start-up, oscillator stabilisation, and a wait for the clock multiplier to lock.

System reset is released when the power-up timer expires. The same event enables the oscillator. When the clock is declared ready, the processor is told to run, and a one-cycle fetch strobe is issued together with a fixed reset vector. If a clock-monitor enable is set, a monitor-arm output rises after a further programmable delay. If either supply flag drops at any point, the chain restarts from the matching hold stage.

Each delay value N holds its stage for N+1 reference cycles, so a value of zero passes the stage in one cycle.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_ok` is low, `stage` reads 0 (power-on stage), `sys_rst` is 1, and `osc_en`, `cpu_run`, `fetch_strobe`, `mon_arm` and `lock_tmo` are 0. The same values hold while `rst_n` is low.
- R2: The first clock edge that sees `por_ok` high starts the power-on delay. The delay lasts `t_por`+1 cycles, and `stage` stays 0 throughout.
- R3: After the power-on delay, `stage` reads 1. The sequencer waits in stage 1 until `bor_ok` is high, spending at least one cycle there, and then runs a `t_bor`+1 cycle delay.
- R4: The power-up timer stage (`stage` = 2) lasts `t_pwrt`+1 cycles. Taken together with R2 and R3, this means `sys_rst` falls on the edge `t_por`+`t_bor`+`t_pwrt`+5 after the first edge that sees both supply flags high.
- R5: `osc_en` is always the inverse of `sys_rst`, so the oscillator is enabled exactly when system reset is released.
- R6: The oscillator stage (`stage` = 3) consists of a start-up delay of `t_osd`+1 cycles and a stabilisation delay of `t_ost`+1 cycles. The lock wait follows them. The run stage (`stage` = 4, `cpu_run` = 1) begins at the first later edge that sees `osc_lock` high.
- R7: If `osc_lock` has not been seen after LOCK_TMO+1 lock-wait cycles, the sequencer enters run anyway and sets `lock_tmo`. This bit stays set, including through supply drops, until `rst_n` is asserted.
- R8: `fetch_strobe` is high for exactly the first cycle of the run stage, and `reset_vec` (24 bits) is always 0x000000.
- R9: With `mon_en` high, `mon_arm` rises `t_fscm`+1 cycles after run entry. It is never high while `mon_en` is low, or outside the run stage.
- R10: A low `por_ok` in any state returns the sequencer to stage 0 on the next edge. A low `bor_ok` in any state past the brown-out hold returns it to stage 1. Either drop asserts `sys_rst` and clears `osc_en`, `cpu_run` and `mon_arm` at that same edge, and the full chain then repeats.
- R11: During an undisturbed power-up, `stage` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| por_ok | input | 1 | Supply above power-on threshold |
| bor_ok | input | 1 | Supply above brown-out threshold |
| osc_lock | input | 1 | Clock multiplier lock indication |
| mon_en | input | 1 | Clock-monitor enable |
| t_por | input | CW | Power-on delay value |
| t_bor | input | CW | Brown-out settle delay value |
| t_pwrt | input | CW | Power-up timer value |
| t_osd | input | CW | Oscillator start-up delay value |
| t_ost | input | CW | Oscillator stabilisation delay value |
| t_fscm | input | CW | Monitor arm delay value |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 1 | Oscillator start enable |
| cpu_run | output | 1 | Processor run indication |
| fetch_strobe | output | 1 | One-cycle fetch start pulse |
| reset_vec | output | VEC_W | Fixed fetch start address |
| mon_arm | output | 1 | Clock-monitor arm |
| lock_tmo | output | 1 | Sticky lock-timeout status |
| stage | output | 3 | Current stage: 0 power-on, 1 brown-out, 2 power-up timer, 3 oscillator, 4 run |

## Verification
Every delay stage is timed against the first edge that sees the supplies good. A corrupted stage counter or a skipped state therefore moves the edge where `sys_rst` falls, or the edge of the fetch pulse, by a whole number of cycles, and that shift shows up in the very power-up where the fault occurs. A state register stuck past a supply drop is caught one cycle after the drop, through `stage`, `sys_rst` or `mon_arm`. A lost timeout flag shows up as a `lock_tmo` that is clear after a forced run entry, or clear after a later supply drop.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

    typedef enum logic [3:0] {
        S_POR_HOLD,
        S_POR_DLY,
        S_BOR_HOLD,
        S_BOR_DLY,
        S_PWRT,
        S_OSC_SU,
        S_OSC_ST,
        S_PLL_WAIT,
        S_RUN
    } seq_state_e;

    typedef enum logic [2:0] {
        STG_POR  = 3'd0,
        STG_BOR  = 3'd1,
        STG_PWRT = 3'd2,
        STG_OSC  = 3'd3,
        STG_RUN  = 3'd4
    } stage_e;

    typedef struct packed {
        seq_state_e st;
        logic       tmo;
    } fsm_reg_t;

    typedef struct packed {
        logic fetch;
        logic arm;
    } arm_reg_t;

    function automatic stage_e stage_of(seq_state_e s);
        case (s)
            S_POR_HOLD, S_POR_DLY:            return STG_POR;
            S_BOR_HOLD, S_BOR_DLY:            return STG_BOR;
            S_PWRT:                           return STG_PWRT;
            S_OSC_SU, S_OSC_ST, S_PLL_WAIT:   return STG_OSC;
            default:                          return STG_RUN;
        endcase
    endfunction

endpackage

// File: rtl/pwrup_dcnt.sv
`timescale 1ns/1ps
module pwrup_dcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R4
    cnt_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/pwrup_fsm.sv
`timescale 1ns/1ps
module pwrup_fsm
    import pwrup_pkg::*;
#(
    parameter int CW       = 16,
    parameter int LOCK_TMO = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_ok,
    input  logic          bor_ok,
    input  logic          osc_lock,
    input  logic [CW-1:0] t_por,
    input  logic [CW-1:0] t_bor,
    input  logic [CW-1:0] t_pwrt,
    input  logic [CW-1:0] t_osd,
    input  logic [CW-1:0] t_ost,
    input  logic          cnt_zero,
    output seq_state_e    state_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          run_enter_o,
    output logic          run_next_o,
    output logic          tmo_o
);
    localparam logic [CW-1:0] LOCK_LIM = CW'(LOCK_TMO);

    fsm_reg_t r_d, r_q;
    logic     tmo_hit;

    always_comb begin
        r_d     = r_q;
        tmo_hit = 1'b0;
        case (r_q.st)
            S_POR_HOLD: if (por_ok)   r_d.st = S_POR_DLY;
            S_POR_DLY:  if (cnt_zero) r_d.st = S_BOR_HOLD;
            S_BOR_HOLD: if (bor_ok)   r_d.st = S_BOR_DLY;
            S_BOR_DLY:  if (cnt_zero) r_d.st = S_PWRT;
            S_PWRT:     if (cnt_zero) r_d.st = S_OSC_SU;
            S_OSC_SU:   if (cnt_zero) r_d.st = S_OSC_ST;
            S_OSC_ST:   if (cnt_zero) r_d.st = S_PLL_WAIT;
            S_PLL_WAIT: begin
                if (osc_lock) begin
                    r_d.st = S_RUN;
                end else if (cnt_zero) begin
                    r_d.st  = S_RUN;
                    tmo_hit = 1'b1;
                end
            end
            default:    r_d.st = S_RUN;
        endcase
        // supply supervision overrides every stage
        if (!por_ok)
            r_d.st = S_POR_HOLD;
        else if (!bor_ok && (r_q.st > S_BOR_HOLD))
            r_d.st = S_BOR_HOLD;
        r_d.tmo = r_q.tmo | (tmo_hit && (r_d.st == S_RUN));

        case (r_d.st)
            S_POR_DLY:  load_val_o = t_por;
            S_BOR_DLY:  load_val_o = t_bor;
            S_PWRT:     load_val_o = t_pwrt;
            S_OSC_SU:   load_val_o = t_osd;
            S_OSC_ST:   load_val_o = t_ost;
            S_PLL_WAIT: load_val_o = LOCK_LIM;
            default:    load_val_o = '0;
        endcase
        load_o      = (r_d.st != r_q.st);
        run_next_o  = (r_d.st == S_RUN);
        run_enter_o = run_next_o && (r_q.st != S_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_POR_HOLD, tmo: 1'b0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;
    assign tmo_o   = r_q.tmo;

    // R10
    por_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (r_q.st == S_POR_HOLD));
    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tmo |=> r_q.tmo);
    // R2
    por_dly_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_POR_DLY) |-> ($past(r_q.st) == S_POR_HOLD || $past(r_q.st) == S_POR_DLY));
endmodule

// File: rtl/pwrup_arm.sv
`timescale 1ns/1ps
module pwrup_arm
    import pwrup_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_enter,
    input  logic          run_next,
    input  logic          mon_en,
    input  logic [CW-1:0] t_fscm,
    output logic          fetch_o,
    output logic          arm_o
);
    arm_reg_t r_d, r_q;
    logic     dly_zero;

    pwrup_dcnt #(.W(CW)) u_fscm_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (run_enter),
        .val_i  (t_fscm),
        .zero_o (dly_zero)
    );

    always_comb begin
        r_d.fetch = run_enter;
        r_d.arm   = run_next && !run_enter && mon_en && (r_q.arm || dly_zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fetch_o = r_q.fetch;
    assign arm_o   = r_q.arm;

    // R8
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fetch |=> !r_q.fetch);
    // R9
    arm_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.arm) |-> $past(mon_en && run_next));
endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int               CW       = 16,
    parameter int               VEC_W    = 24,
    parameter int               LOCK_TMO = 1000,
    parameter logic [VEC_W-1:0] RST_VEC  = '0
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             bor_ok,
    input  logic             osc_lock,
    input  logic             mon_en,
    input  logic [CW-1:0]    t_por,
    input  logic [CW-1:0]    t_bor,
    input  logic [CW-1:0]    t_pwrt,
    input  logic [CW-1:0]    t_osd,
    input  logic [CW-1:0]    t_ost,
    input  logic [CW-1:0]    t_fscm,
    output logic             sys_rst,
    output logic             osc_en,
    output logic             cpu_run,
    output logic             fetch_strobe,
    output logic [VEC_W-1:0] reset_vec,
    output logic             mon_arm,
    output logic             lock_tmo,
    output logic [2:0]       stage
);
    seq_state_e    state;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          cnt_zero;
    logic          run_enter, run_next;

    pwrup_fsm #(.CW(CW), .LOCK_TMO(LOCK_TMO)) u_fsm (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .por_ok      (por_ok),
        .bor_ok      (bor_ok),
        .osc_lock    (osc_lock),
        .t_por       (t_por),
        .t_bor       (t_bor),
        .t_pwrt      (t_pwrt),
        .t_osd       (t_osd),
        .t_ost       (t_ost),
        .cnt_zero    (cnt_zero),
        .state_o     (state),
        .load_o      (ld),
        .load_val_o  (ld_val),
        .run_enter_o (run_enter),
        .run_next_o  (run_next),
        .tmo_o       (lock_tmo)
    );

    pwrup_dcnt #(.W(CW)) u_stage_cnt (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .zero_o (cnt_zero)
    );

    pwrup_arm #(.CW(CW)) u_arm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .run_enter (run_enter),
        .run_next  (run_next),
        .mon_en    (mon_en),
        .t_fscm    (t_fscm),
        .fetch_o   (fetch_strobe),
        .arm_o     (mon_arm)
    );

    assign sys_rst   = (state < S_OSC_SU);
    assign osc_en    = !sys_rst;
    assign cpu_run   = (state == S_RUN);
    assign reset_vec = RST_VEC;
    assign stage     = stage_of(state);

    // R8
    run_fetch_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(cpu_run) |-> fetch_strobe);
    // R9
    arm_in_run_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mon_arm |-> cpu_run);
endmodule

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;
    localparam int CW    = 16;
    localparam int LT    = 40;
    localparam int NEVER = 999;
    localparam int NROW  = 5;
    localparam int NCYC  = 100;

    // tp, tb, tw, ts, tt, tf, lock_at (0 = from start, NEVER = none), mon_en
    localparam int TBL [0:NROW-1][0:7] = '{
        '{3, 2, 5, 2, 3, 4, 0,     1},
        '{0, 0, 0, 0, 0, 0, 0,     1},
        '{1, 4, 0, 1, 1, 2, NEVER, 1},
        '{2, 2, 3, 0, 2, 1, 30,    0},
        '{5, 1, 10, 3, 4, 0, 0,    1}
    };

    logic clk = 1'b0;
    logic rst_n, por_ok, bor_ok, osc_lock, mon_en;
    logic [CW-1:0] t_por, t_bor, t_pwrt, t_osd, t_ost, t_fscm;
    logic sys_rst, osc_en, cpu_run, fetch_strobe, mon_arm, lock_tmo;
    logic [23:0] reset_vec;
    logic [2:0]  stage;

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    pwrup_seq #(.CW(CW), .VEC_W(24), .LOCK_TMO(LT)) i_pwrup_seq (
        .clk_ref(clk), .rst_n(rst_n), .por_ok(por_ok), .bor_ok(bor_ok),
        .osc_lock(osc_lock), .mon_en(mon_en), .t_por(t_por), .t_bor(t_bor),
        .t_pwrt(t_pwrt), .t_osd(t_osd), .t_ost(t_ost), .t_fscm(t_fscm),
        .sys_rst(sys_rst), .osc_en(osc_en), .cpu_run(cpu_run),
        .fetch_strobe(fetch_strobe), .reset_vec(reset_vec), .mon_arm(mon_arm),
        .lock_tmo(lock_tmo), .stage(stage)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int tp, input int tb, input int tw,
                       input int ts, input int tt, input int tf);
        t_por = CW'(tp); t_bor = CW'(tb); t_pwrt = CW'(tw);
        t_osd = CW'(ts); t_ost = CW'(tt); t_fscm = CW'(tf);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; por_ok = 1'b0; bor_ok = 1'b0; osc_lock = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic run_row(input int r);
        int tp, tb, tw, ts, tt, tf, la, me;
        int rel, p, run_exp, arm_exp, tmo_exp;
        int rst_fall, fetch_at, fetch_n, arm_at, prev_stg, mono_bad, inv_bad, vec_bad;
        tp = TBL[r][0]; tb = TBL[r][1]; tw = TBL[r][2];
        ts = TBL[r][3]; tt = TBL[r][4]; tf = TBL[r][5];
        la = TBL[r][6]; me = TBL[r][7];
        cfg(tp, tb, tw, ts, tt, tf);
        mon_en = me[0];
        do_reset();
        rel = tp + tb + tw + 5;
        p   = rel + ts + tt + 2;
        if (la == NEVER) begin
            run_exp = p + LT + 1; tmo_exp = 1;
        end else begin
            run_exp = (la + 1 > p + 1) ? la + 1 : p + 1; tmo_exp = 0;
        end
        arm_exp = me ? run_exp + tf + 1 : NEVER;
        rst_fall = NEVER; fetch_at = NEVER; arm_at = NEVER;
        fetch_n = 0; prev_stg = 0; mono_bad = 0; inv_bad = 0; vec_bad = 0;
        por_ok = 1'b1; bor_ok = 1'b1;
        if (la == 0) osc_lock = 1'b1;
        for (int k = 1; k <= NCYC; k++) begin
            @(negedge clk);
            if (!sys_rst && rst_fall == NEVER) rst_fall = k;
            if (fetch_strobe) begin
                fetch_n++;
                if (fetch_at == NEVER) fetch_at = k;
            end
            if (mon_arm && arm_at == NEVER) arm_at = k;
            if (int'(stage) < prev_stg) mono_bad++;
            prev_stg = int'(stage);
            if (osc_en != !sys_rst) inv_bad++;
            if (reset_vec != 24'h0) vec_bad++;
            if (k == la) osc_lock = 1'b1;
        end
        chk($sformatf("R4 row%0d sys_rst release cycle", r), rst_fall, rel);
        chk($sformatf("R6 row%0d run entry cycle", r), fetch_at, run_exp);
        chk($sformatf("R8 row%0d fetch pulse count", r), fetch_n, 1);
        chk($sformatf("R8 row%0d reset vector nonzero samples", r), vec_bad, 0);
        chk($sformatf("R9 row%0d monitor arm cycle", r), arm_at, arm_exp);
        chk($sformatf("R7 row%0d lock timeout flag", r), int'(lock_tmo), tmo_exp);
        chk($sformatf("R11 row%0d stage decreases", r), mono_bad, 0);
        chk($sformatf("R5 row%0d osc_en mismatches", r), inv_bad, 0);
        chk($sformatf("R6 row%0d final stage run", r), int'(stage), 4);
    endtask

    initial begin
        #900us;
        errs++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_ok = 1'b1; bor_ok = 1'b1; osc_lock = 1'b1; mon_en = 1'b1;
        cfg(0, 0, 0, 0, 0, 0);
        cyc(3);
        // R1 reset state with supplies already good
        chk("R1 reset sys_rst", int'(sys_rst), 1);
        chk("R1 reset osc_en", int'(osc_en), 0);
        chk("R1 reset cpu_run", int'(cpu_run), 0);
        chk("R1 reset fetch_strobe", int'(fetch_strobe), 0);
        chk("R1 reset mon_arm", int'(mon_arm), 0);
        chk("R1 reset lock_tmo", int'(lock_tmo), 0);
        chk("R1 reset stage", int'(stage), 0);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R1 held in power-on stage while por_ok low
        cfg(2, 1, 2, 1, 1, 3);
        mon_en = 1'b1;
        do_reset();
        bor_ok = 1'b1; osc_lock = 1'b1;
        cyc(20);
        chk("R1 por low stage", int'(stage), 0);
        chk("R1 por low sys_rst", int'(sys_rst), 1);

        // R3 held in brown-out stage while bor_ok low
        por_ok = 1'b1; bor_ok = 1'b0;
        cyc(20);
        chk("R3 bor low stage", int'(stage), 1);
        chk("R3 bor low sys_rst", int'(sys_rst), 1);

        bor_ok = 1'b1;
        cyc(40);
        chk("R6 run reached", int'(cpu_run), 1);
        chk("R9 armed in run", int'(mon_arm), 1);
        mon_en = 1'b0;
        cyc(1);
        chk("R9 arm drops with mon_en low", int'(mon_arm), 0);
        chk("R9 run unaffected by mon_en", int'(cpu_run), 1);
        mon_en = 1'b1;
        cyc(1);
        chk("R9 rearm after mon_en high", int'(mon_arm), 1);

        // R10 brown-out drop from run
        bor_ok = 1'b0;
        cyc(1);
        chk("R10 bor drop stage", int'(stage), 1);
        chk("R10 bor drop sys_rst", int'(sys_rst), 1);
        chk("R10 bor drop osc_en", int'(osc_en), 0);
        chk("R10 bor drop cpu_run", int'(cpu_run), 0);
        chk("R10 bor drop mon_arm", int'(mon_arm), 0);
        por_ok = 1'b0;
        cyc(1);
        chk("R10 por drop stage", int'(stage), 0);

        // R10 full chain repeats after recovery
        begin
            int fall;
            fall = NEVER;
            por_ok = 1'b1; bor_ok = 1'b1;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (!sys_rst && fall == NEVER) fall = k;
            end
            chk("R10 restart release cycle", fall, 2 + 1 + 2 + 5);
        end

        // R10 power-on drop during power-up timer
        cfg(0, 0, 50, 0, 0, 0);
        do_reset();
        por_ok = 1'b1; bor_ok = 1'b1;
        cyc(15);
        chk("R4 in power-up timer stage", int'(stage), 2);
        por_ok = 1'b0;
        cyc(1);
        chk("R10 por drop in timer stage", int'(stage), 0);

        // R7 timeout flag is sticky across supply drops, cleared by rst_n
        cfg(0, 0, 0, 0, 0, 0);
        do_reset();
        por_ok = 1'b1; bor_ok = 1'b1;
        cyc(LT + 15);
        chk("R7 timeout reached run", int'(cpu_run), 1);
        chk("R7 timeout flag set", int'(lock_tmo), 1);
        por_ok = 1'b0; bor_ok = 1'b0;
        cyc(5);
        chk("R7 flag kept after drop", int'(lock_tmo), 1);
        rst_n = 1'b0;
        cyc(1);
        chk("R7 flag cleared by reset", int'(lock_tmo), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule